// File: doc/BRIEF.md
# PCI bridge parity error handler

This block checks and reports parity for a two-port PCI-to-PCI bridge. Each side of the bridge presents its bus activity to it one phase at a time: the AD and C/BE values with a valid strobe and flags giving the phase type. The matching PAR bit arrives one clock later. The block checks even parity across AD, C/BE and PAR. From the result it decides whether the bridge claims a secondary address phase. It drives active-low error strobes on both sides and keeps four sticky status bits. The parity-response and system-error enables come in as plain inputs from the bridge's configuration registers.

On the primary side only Type 0 configuration writes aimed at the bridge's own registers are checked. Other primary phases are not looked at. On the secondary side the block checks address phases and the data phases of downstream reads. Read data goes into a small forwarding queue together with its C/BE and the PAR bit exactly as received, so bad parity reaches the primary initiator unchanged. Prefetched data that the primary side never takes can be flushed, and its parity is then never presented.

Top module: `pci_parity_guard`

## Requirements
- R1: `p_trdy_o` is high in every cycle that carries a primary configuration-write phase (`p_valid_i` and `p_cfgwr_i` high). Parity has no effect on it, so the register write always completes.
- R2: If the PAR sampled one cycle after a configuration-write phase mismatches and `pri_perr_en_i` is high in that cycle, `p_perr_no` goes low for one clock in the next cycle, two clocks after the phase. If the enable is low, `p_perr_no` stays high.
- R3: `status_o[0]` (primary detected parity error) is set by a configuration-write parity error whatever the value of `pri_perr_en_i`.
- R4: `s_claim_o` pulses high two cycles after a secondary address phase that has `s_hit_i` high, unless that phase has a parity error and `sec_perr_en_i` is high. In that case the bridge does not claim the phase. Address phases with `s_hit_i` low are never claimed.
- R5: `status_o[2]` (secondary detected parity error) is set by any secondary address or read-data parity error, whatever the enables.
- R6: A secondary address parity error drives `p_serr_no` low for one clock two cycles after the phase and sets `status_o[1]` (system error signaled). Both happen only when `serr_en_i` and `sec_perr_en_i` are both high.
- R7: A secondary read-data parity error drives `s_perr_no` low for one clock two cycles after the data phase, only if `sec_perr_en_i` is high.
- R8: `status_o[3]` (secondary data parity detected) is set by a read-data parity error only when `sec_perr_en_i` is high.
- R9: Every secondary read data phase is queued with its AD, C/BE and the PAR bit as received, whether or not the parity is good, and entries come out in arrival order. The entry becomes visible on the `fwd_*` outputs the cycle after its PAR is sampled. `fwd_valid_o` shows that the head is present, and `fwd_take_i` removes the head. A take on an empty queue does nothing.
- R10: `fwd_flush_i` discards every queued entry, including one being pushed in the same cycle. Discarded data, and its parity, never appear on the `fwd_*` outputs.
- R11: The status bits are sticky and are cleared by writing 1 to the matching bit of `stat_clr_i`. When a set and a clear hit the same bit in the same cycle, the set wins.
- R12: Parity is good when the XOR of the 32 AD bits, the 4 C/BE bits and PAR is 0. Primary phases that are not configuration writes are ignored, whatever their parity.
- R13: The queue holds `FWD_DEPTH` entries. A push into a full queue is dropped unless the head is taken in the same cycle, in which case the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_perr_en_i | input | 1 | Primary parity-response enable (command register) |
| serr_en_i | input | 1 | System-error enable (command register) |
| sec_perr_en_i | input | 1 | Secondary parity-response enable (bridge control) |
| p_valid_i | input | 1 | Primary phase valid |
| p_cfgwr_i | input | 1 | Primary phase is a Type 0 config write data phase to the bridge |
| p_ad_i | input | AD_W | Primary AD |
| p_cbe_i | input | BE_W | Primary C/BE |
| p_par_i | input | 1 | Primary PAR, covering the previous cycle's phase |
| p_trdy_o | output | 1 | Config write accepted and register written |
| p_perr_no | output | 1 | Primary PERR, active low |
| p_serr_no | output | 1 | Primary SERR, active low |
| s_valid_i | input | 1 | Secondary phase valid |
| s_addr_i | input | 1 | Secondary phase is an address phase |
| s_rd_i | input | 1 | Secondary phase is downstream read data |
| s_hit_i | input | 1 | Address decodes to or through the bridge |
| s_ad_i | input | AD_W | Secondary AD |
| s_cbe_i | input | BE_W | Secondary C/BE |
| s_par_i | input | 1 | Secondary PAR, covering the previous cycle's phase |
| s_claim_o | output | 1 | Bridge claims the address phase (DEVSEL decision) |
| s_perr_no | output | 1 | Secondary PERR, active low |
| fwd_take_i | input | 1 | Primary side takes the queue head |
| fwd_flush_i | input | 1 | Discard all forwarded read data |
| fwd_valid_o | output | 1 | Queue head present |
| fwd_ad_o | output | AD_W | Forwarded AD |
| fwd_cbe_o | output | BE_W | Forwarded C/BE |
| fwd_par_o | output | 1 | Forwarded PAR, unchanged |
| stat_clr_i | input | 4 | Write-1-to-clear for status bits |
| status_o | output | 4 | Sticky status: [0] primary detected, [1] system error signaled, [2] secondary detected, [3] secondary data parity detected |

## Verification
Two pairs of events can land on the same clock edge. In the first, a detected parity error sets a status bit at the edge where software writes 1 to clear it. The bench provokes this by raising `stat_clr_i` in the cycle that carries the bad PAR, and the bit must read as set afterwards. In the second, a read entry is pushed into the queue at the edge where a flush or a take also arrives. The bench provokes this by asserting the flush or the take in the cycle where the read's PAR arrives, and its queue model must agree with the `fwd_*` outputs on every clock that follows.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;
  localparam int ST_W        = 4;
  localparam int ST_PRI_DET  = 0;
  localparam int ST_SIG_SERR = 1;
  localparam int ST_SEC_DET  = 2;
  localparam int ST_SEC_DPD  = 3;

  typedef struct packed {
    logic hit;
    logic rd;
    logic addr;
  } s_kind_t;
endpackage

// File: rtl/pci_par_stage.sv
// Captures a phase, checks it against PAR on the following cycle.
module pci_par_stage #(
  parameter int AD_W = 32,
  parameter int BE_W = 4,
  parameter int KW   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [KW-1:0] kind_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic          par_i,
  output logic          v_o,
  output logic [KW-1:0] kind_o,
  output logic          bad_o
);
  logic          v_q;
  logic          x_q;
  logic [KW-1:0] kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      x_q    <= 1'b0;
      kind_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        x_q    <= ^{ad_i, cbe_i};
        kind_q <= kind_i;
      end
    end
  end

  assign v_o    = v_q;
  assign kind_o = kind_q;
  assign bad_o  = v_q & (x_q ^ par_i);
endmodule

// File: rtl/pci_status_w1c.sv
module pci_status_w1c #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;  // set beats clear
  end

  assign q_o = q;
endmodule

// File: rtl/pci_rd_fwd_fifo.sv
module pci_rd_fwd_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  input  logic         flush_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          pop, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop     = take_i & (cnt_q != '0);
  assign push_ok = push_i & ((cnt_q != CW'(DEPTH)) | pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop)     rd_q <= nxt(rd_q);
      case ({push_ok, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_q] <= data_i;
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
  import pci_parity_pkg::*;
#(
  parameter int AD_W      = 32,
  parameter int BE_W      = 4,
  parameter int FWD_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pri_perr_en_i,
  input  logic            serr_en_i,
  input  logic            sec_perr_en_i,
  input  logic            p_valid_i,
  input  logic            p_cfgwr_i,
  input  logic [AD_W-1:0] p_ad_i,
  input  logic [BE_W-1:0] p_cbe_i,
  input  logic            p_par_i,
  output logic            p_trdy_o,
  output logic            p_perr_no,
  output logic            p_serr_no,
  input  logic            s_valid_i,
  input  logic            s_addr_i,
  input  logic            s_rd_i,
  input  logic            s_hit_i,
  input  logic [AD_W-1:0] s_ad_i,
  input  logic [BE_W-1:0] s_cbe_i,
  input  logic            s_par_i,
  output logic            s_claim_o,
  output logic            s_perr_no,
  input  logic            fwd_take_i,
  input  logic            fwd_flush_i,
  output logic            fwd_valid_o,
  output logic [AD_W-1:0] fwd_ad_o,
  output logic [BE_W-1:0] fwd_cbe_o,
  output logic            fwd_par_o,
  input  logic [ST_W-1:0] stat_clr_i,
  output logic [ST_W-1:0] status_o
);
  localparam int SKW   = $bits(s_kind_t);
  localparam int FWD_W = AD_W + BE_W + 1;

  // primary: config-write data phases only
  logic p_cfg_ph, p_v, p_bad;
  logic [0:0] p_k;

  assign p_cfg_ph = p_valid_i & p_cfgwr_i;
  assign p_trdy_o = p_cfg_ph;  // completes regardless of parity

  pci_par_stage #(.AD_W(AD_W), .BE_W(BE_W), .KW(1)) u_pri_stage (
    .clk_i, .rst_ni,
    .valid_i(p_cfg_ph), .kind_i(1'b1),
    .ad_i(p_ad_i), .cbe_i(p_cbe_i), .par_i(p_par_i),
    .v_o(p_v), .kind_o(p_k), .bad_o(p_bad)
  );

  // secondary: address and read-data phases
  s_kind_t s_kin, s_k;
  logic    s_ph, s_v, s_bad;

  assign s_kin = '{hit: s_hit_i, rd: s_rd_i, addr: s_addr_i};
  assign s_ph  = s_valid_i & (s_addr_i | s_rd_i);

  pci_par_stage #(.AD_W(AD_W), .BE_W(BE_W), .KW(SKW)) u_sec_stage (
    .clk_i, .rst_ni,
    .valid_i(s_ph), .kind_i(s_kin),
    .ad_i(s_ad_i), .cbe_i(s_cbe_i), .par_i(s_par_i),
    .v_o(s_v), .kind_o(s_k), .bad_o(s_bad)
  );

  logic cfg_err, addr_err, rd_err;
  assign cfg_err  = p_bad & p_v & p_k[0];
  assign addr_err = s_bad & s_k.addr;
  assign rd_err   = s_bad & s_k.rd;

  logic p_perr_q, s_perr_q, serr_q, claim_q;
  logic serr_evt;
  assign serr_evt = addr_err & serr_en_i & sec_perr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_perr_q <= 1'b0;
      s_perr_q <= 1'b0;
      serr_q   <= 1'b0;
      claim_q  <= 1'b0;
    end else begin
      p_perr_q <= cfg_err & pri_perr_en_i;
      s_perr_q <= rd_err & sec_perr_en_i;
      serr_q   <= serr_evt;
      claim_q  <= s_v & s_k.addr & s_k.hit & ~(s_bad & sec_perr_en_i);
    end
  end

  assign p_perr_no = ~p_perr_q;
  assign s_perr_no = ~s_perr_q;
  assign p_serr_no = ~serr_q;
  assign s_claim_o = claim_q;

  // status
  logic [ST_W-1:0] st_set;
  always_comb begin
    st_set              = '0;
    st_set[ST_PRI_DET]  = cfg_err;
    st_set[ST_SIG_SERR] = serr_evt;
    st_set[ST_SEC_DET]  = addr_err | rd_err;
    st_set[ST_SEC_DPD]  = rd_err & sec_perr_en_i;
  end

  pci_status_w1c #(.W(ST_W)) u_status (
    .clk_i, .rst_ni, .set_i(st_set), .clr_i(stat_clr_i), .q_o(status_o)
  );

  // read data forwarding, parity carried unchanged
  logic [AD_W-1:0] s_ad_q;
  logic [BE_W-1:0] s_cbe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_ad_q  <= '0;
      s_cbe_q <= '0;
    end else if (s_valid_i && s_rd_i) begin
      s_ad_q  <= s_ad_i;
      s_cbe_q <= s_cbe_i;
    end
  end

  logic [FWD_W-1:0] fwd_d;

  pci_rd_fwd_fifo #(.W(FWD_W), .DEPTH(FWD_DEPTH)) u_fwd (
    .clk_i, .rst_ni,
    .push_i(s_v & s_k.rd), .data_i({s_ad_q, s_cbe_q, s_par_i}),
    .take_i(fwd_take_i), .flush_i(fwd_flush_i),
    .valid_o(fwd_valid_o), .data_o(fwd_d)
  );

  assign {fwd_ad_o, fwd_cbe_o, fwd_par_o} = fwd_d;
endmodule

// File: rtl/pci_parity_guard_chk.sv
module pci_parity_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pri_perr_en_i,
  input logic       serr_en_i,
  input logic       sec_perr_en_i,
  input logic       p_trdy_o,
  input logic       p_perr_no,
  input logic       p_serr_no,
  input logic       s_valid_i,
  input logic       s_addr_i,
  input logic       s_hit_i,
  input logic       s_claim_o,
  input logic       s_perr_no,
  input logic [3:0] stat_clr_i,
  input logic [3:0] status_o
);
  // R2
  pri_perr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_perr_no |-> $past(pri_perr_en_i));

  // R2
  pri_perr_follows_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_perr_no |-> $past(p_trdy_o, 2));

  // R3
  pri_perr_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_perr_no |-> status_o[0]);

  // R4
  claim_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_claim_o |-> $past(s_valid_i && s_addr_i && s_hit_i, 2));

  // R6
  serr_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_serr_no |-> ($past(serr_en_i) && $past(sec_perr_en_i) && status_o[1]));

  // R7
  sec_perr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_perr_no |-> $past(sec_perr_en_i));

  // R8
  dpd_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(sec_perr_en_i));

  // R11
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~$past(stat_clr_i)) & ~status_o) == 4'b0);
endmodule

bind pci_parity_guard pci_parity_guard_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pri_perr_en_i(pri_perr_en_i), .serr_en_i(serr_en_i), .sec_perr_en_i(sec_perr_en_i),
  .p_trdy_o(p_trdy_o), .p_perr_no(p_perr_no), .p_serr_no(p_serr_no),
  .s_valid_i(s_valid_i), .s_addr_i(s_addr_i), .s_hit_i(s_hit_i),
  .s_claim_o(s_claim_o), .s_perr_no(s_perr_no),
  .stat_clr_i(stat_clr_i), .status_o(status_o)
);

// File: tb/pci_parity_guard_test.sv
`timescale 1ns/1ps
module pci_parity_guard_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic pri_en = 0, serr_en = 0, sec_en = 0;
  logic p_valid = 0, p_cfgwr = 0, p_par = 0;
  logic [31:0] p_ad = 0;
  logic [3:0]  p_cbe = 0;
  logic s_valid = 0, s_addr = 0, s_rd = 0, s_hit = 0, s_par = 0;
  logic [31:0] s_ad = 0;
  logic [3:0]  s_cbe = 0;
  logic take = 0, flush = 0;
  logic [3:0] clr = 0;

  logic p_trdy, p_perr_n, p_serr_n, s_claim, s_perr_n, fwd_valid, fwd_par;
  logic [31:0] fwd_ad;
  logic [3:0] fwd_cbe, status;

  pci_parity_guard #(.AD_W(32), .BE_W(4), .FWD_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pri_perr_en_i(pri_en), .serr_en_i(serr_en), .sec_perr_en_i(sec_en),
    .p_valid_i(p_valid), .p_cfgwr_i(p_cfgwr), .p_ad_i(p_ad), .p_cbe_i(p_cbe),
    .p_par_i(p_par), .p_trdy_o(p_trdy), .p_perr_no(p_perr_n), .p_serr_no(p_serr_n),
    .s_valid_i(s_valid), .s_addr_i(s_addr), .s_rd_i(s_rd), .s_hit_i(s_hit),
    .s_ad_i(s_ad), .s_cbe_i(s_cbe), .s_par_i(s_par),
    .s_claim_o(s_claim), .s_perr_no(s_perr_n),
    .fwd_take_i(take), .fwd_flush_i(flush), .fwd_valid_o(fwd_valid),
    .fwd_ad_o(fwd_ad), .fwd_cbe_o(fwd_cbe), .fwd_par_o(fwd_par),
    .stat_clr_i(clr), .status_o(status)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string ctx = "reset";

  // reference model state
  bit m_pv, m_px, m_sv, m_sa, m_sr, m_sh, m_sx;
  logic [31:0] m_sad;
  logic [3:0]  m_scbe;
  bit e_pperr, e_sperr, e_serr, e_claim;
  logic [3:0] e_stat;
  logic [36:0] q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pv = 0; m_px = 0; m_sv = 0; m_sa = 0; m_sr = 0; m_sh = 0; m_sx = 0;
      m_sad = 0; m_scbe = 0;
      e_pperr = 0; e_sperr = 0; e_serr = 0; e_claim = 0; e_stat = 0;
      q.delete();
    end else begin
      bit bp, bs;
      logic [3:0] set;
      bp = m_pv && (m_px != p_par);
      bs = m_sv && (m_sx != s_par);
      e_pperr = bp && pri_en;
      e_sperr = bs && m_sr && sec_en;
      e_serr  = bs && m_sa && serr_en && sec_en;
      e_claim = m_sv && m_sa && m_sh && !(bs && sec_en);
      set = {bs && m_sr && sec_en, bs && (m_sa || m_sr), e_serr, bp};
      e_stat = (e_stat & ~clr) | set;
      if (flush) q.delete();
      else begin
        if (take && q.size() > 0) void'(q.pop_front());
        if (m_sv && m_sr && q.size() < DEPTH) q.push_back({m_sad, m_scbe, s_par});
      end
      m_pv = p_valid && p_cfgwr; m_px = ^{p_ad, p_cbe};
      m_sv = s_valid && (s_addr || s_rd); m_sa = s_addr; m_sr = s_rd; m_sh = s_hit;
      m_sx = ^{s_ad, s_cbe}; m_sad = s_ad; m_scbe = s_cbe;
    end
  end

  task automatic chk(input logic [36:0] act, input logic [36:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(37'(p_trdy), 37'(p_valid && p_cfgwr), "R1");
    chk(37'(p_perr_n), 37'(!e_pperr), "R2");
    chk(37'(s_perr_n), 37'(!e_sperr), "R7");
    chk(37'(p_serr_n), 37'(!e_serr), "R6");
    chk(37'(s_claim), 37'(e_claim), "R4");
    chk(37'(status[0]), 37'(e_stat[0]), "R3");
    chk(37'(status[1]), 37'(e_stat[1]), "R6");
    chk(37'(status[2]), 37'(e_stat[2]), "R5");
    chk(37'(status[3]), 37'(e_stat[3]), "R8");
    chk(37'(fwd_valid), 37'(q.size() > 0), "R9");
    if (q.size() > 0) chk({fwd_ad, fwd_cbe, fwd_par}, q[0], "R9");
  endtask

  // next-cycle stimulus
  bit n_pv, n_pcfg, n_ppar, n_sv, n_sa, n_sr, n_sh, n_spar, n_take, n_flush;
  logic [31:0] n_pad, n_sad;
  logic [3:0]  n_pcbe, n_scbe, n_clr;
  bit pend_p, pend_s;

  task automatic setp(input bit cfg, input bit bad);
    n_pv = 1; n_pcfg = cfg; n_pad = $urandom; n_pcbe = 4'($urandom);
    n_ppar = (^{n_pad, n_pcbe}) ^ bad;
  endtask

  task automatic sets(input bit a, input bit r, input bit h, input bit bad, input bit adflip);
    n_sv = 1; n_sa = a; n_sr = r; n_sh = h; n_sad = $urandom; n_scbe = 4'($urandom);
    n_spar = ^{n_sad, n_scbe};
    if (bad) begin
      if (adflip) n_sad[$urandom_range(31, 0)] ^= 1'b1;
      else        n_spar ^= 1'b1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    p_par = pend_p; s_par = pend_s;
    p_valid = n_pv; p_cfgwr = n_pcfg; p_ad = n_pad; p_cbe = n_pcbe; pend_p = n_ppar;
    s_valid = n_sv; s_addr = n_sa; s_rd = n_sr; s_hit = n_sh;
    s_ad = n_sad; s_cbe = n_scbe; pend_s = n_spar;
    take = n_take; flush = n_flush; clr = n_clr;
    n_pv = 0; n_pcfg = 0; n_ppar = 0; n_sv = 0; n_sa = 0; n_sr = 0; n_sh = 0; n_spar = 0;
    n_take = 0; n_flush = 0; n_clr = 0; n_pad = 0; n_pcbe = 0; n_sad = 0; n_scbe = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ctx = "reset";
    idle(2);

    for (int c = 0; c < 8; c++) begin
      {pri_en, serr_en, sec_en} = 3'(c);
      ctx = $sformatf("R12 combo %0d", c);
      setp(1, 0); step();
      setp(1, 1); step();
      setp(0, 1); step();                 // not a cfg write: ignored (R12)
      idle(2);
      sets(1, 0, 1, 0, 0); step();
      sets(1, 0, 1, 1, 0); step();
      sets(1, 0, 0, 1, 1); step();
      sets(1, 0, 1, 1, 1); step();
      idle(2);
      sets(0, 1, 0, 0, 0); step();
      sets(0, 1, 0, 1, 1); step();
      sets(0, 1, 0, 1, 0); step();
      idle(2);
      for (int t = 0; t < 3; t++) begin n_take = 1; step(); end
      n_take = 1; step();                  // take on empty
      n_clr = 4'hF; step();
      idle(1);
    end

    {pri_en, serr_en, sec_en} = 3'b111;
    ctx = "R2 R7 back-to-back";
    setp(1, 1); sets(0, 1, 0, 1, 0); step();
    setp(1, 1); sets(1, 0, 1, 1, 0); step();
    setp(1, 0); sets(0, 1, 0, 0, 0); step();
    idle(3);
    for (int t = 0; t < 2; t++) begin n_take = 1; step(); end
    n_clr = 4'hF; step();
    idle(1);

    ctx = "R11 set vs clear";
    setp(1, 1); sets(1, 0, 1, 1, 0); step();
    n_clr = 4'hF; step();
    idle(2);
    n_clr = 4'b0101; step();
    idle(1);
    sets(0, 1, 0, 1, 0); step();
    n_clr = 4'hF; step();
    idle(2);
    n_clr = 4'hF; step();
    idle(1);

    ctx = "R10 flush";
    sets(0, 1, 0, 0, 0); step();
    sets(0, 1, 0, 1, 0); step();
    sets(0, 1, 0, 0, 0); step();
    n_flush = 1; step();                   // same cycle as last push
    idle(2);
    n_take = 1; step();
    sets(0, 1, 0, 1, 1); step();
    idle(2);
    n_flush = 1; step();
    idle(2);

    ctx = "R13 full";
    for (int k = 0; k < 6; k++) begin sets(0, 1, 0, k[0], 0); step(); end
    idle(2);
    sets(0, 1, 0, 0, 0); step();
    n_take = 1; step();                    // take with push while full
    idle(1);
    for (int t = 0; t < 5; t++) begin n_take = 1; step(); end
    sets(0, 1, 0, 0, 0); n_take = 1; step();
    sets(0, 1, 0, 1, 0); n_take = 1; step();
    n_take = 1; step();
    n_take = 1; step();
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule